// File: doc/BRIEF.md
# Embedded Program and Erase Sequencer

This block runs the self-timed write algorithms of a flash-style array. A command front end gives it a one-cycle start strobe with an operation code, an address, a data word and a block number. From then on the block works alone. It times every pulse, reads each location back to check it, and counts retries. The host only waits for a done or fail indication.

A program operation lowers bits at one address and then checks them. An erase works on the whole array or on one of its equal-sized blocks. It first drives every location in that range to zero and checks it. It then gives timed erase pulses. After each pulse it reads the range back from the bottom. The scan stops at the first location that is not all ones, and the next pulse follows. An erase may be parked between pulses and later resumed.

The array side is a plain synchronous port. The block drives an address, a write-zero strobe with its data, and an erase strobe with a low and a high range bound. The read data returns combinationally for the current address.

Top module: `flash_algo_seq`

## Requirements
- R1: During and after reset, busy, done, suspended, prog_fail, erase_fail, arr_prog and arr_erase are all low.
- R2: For a program start (op 2'b01), arr_prog is high for exactly PROG_PULSE cycles with arr_addr = start_addr and arr_wdata = start_data. A verify read follows. If the read equals the data, done is high for one cycle, and busy drops in that same cycle.
- R3: A program gives at most PROG_RETRY pulses. If the read-back still differs, for example because a 0 bit would have to return to 1, prog_fail rises without done. prog_fail stays high until the next accepted start.
- R4: A chip erase (op 2'b10) covers addresses 0 to DEPTH-1. It first gives one or more program pulses with data 0 to each address, in ascending order, before any erase pulse. Each address is verified as zero before the next one.
- R5: A block erase (op 2'b11) of block b covers addresses b*BLK_SIZE to b*BLK_SIZE+BLK_SIZE-1. It pre-programs and erases only that range. Locations outside the range keep their contents.
- R6: Each erase pulse holds arr_erase for exactly ERASE_PULSE cycles. A verify scan follows, ascending from the low bound. It stops at the first location that is not all ones. A full passing scan ends the erase with done.
- R7: An erase gives at most ERASE_RETRY pulses. If the scan after the last pulse still fails, erase_fail rises without done.
- R8: A suspend_req seen during the erase-pulse phase takes effect only after the current pulse and a failing scan. The block then shows suspended with busy still high, and gives no pulses. A resume_req rescans from the low bound and then continues. A suspend_req outside an erase has no effect.
- R9: A start during busy is ignored, and so is a start with op 2'b00.
- R10: A block number of NUM_BLOCKS or above raises erase_fail one cycle after the start, with no pulse and without busy. A location that cannot be pre-programmed within PROG_RETRY pulses raises erase_fail before any erase pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle operation start strobe |
| op | input | 2 | 01 program, 10 chip erase, 11 block erase |
| start_addr | input | ADDR_W | Program address |
| start_data | input | DATA_W | Program data |
| blk_sel | input | BSEL_W | Block number for block erase |
| suspend_req | input | 1 | Request to park an erase between pulses |
| resume_req | input | 1 | Leave the suspended state |
| arr_rdata | input | DATA_W | Array read data for arr_addr |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | DATA_W | Data for write-zero pulse |
| arr_prog | output | 1 | Write-zero strobe |
| arr_erase | output | 1 | Erase strobe for the range |
| arr_lo | output | ADDR_W | Erase range low bound |
| arr_hi | output | ADDR_W | Erase range high bound |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| prog_fail | output | 1 | Program retry limit reached |
| erase_fail | output | 1 | Erase failure |
| suspended | output | 1 | Erase parked |

## Verification
Every address is programmed once with a data value that depends on the address. This shows that the address and the data reach the array. Per-cell pulse thresholds from one up to one past the retry limit separate a correct retry count from an off-by-one. Chip erase and each of the five blocks are erased over a patterned array. Per-block checks of the contents and pulse logs show whether range decoding, pre-program order and the erase retry limit are right. Invalid block numbers, a cell that cannot be programmed, starts during busy, and suspends placed inside and outside an erase cover the side paths.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
    localparam logic [1:0] OP_NONE  = 2'b00;
    localparam logic [1:0] OP_PROG  = 2'b01;
    localparam logic [1:0] OP_CHIP  = 2'b10;
    localparam logic [1:0] OP_BLOCK = 2'b11;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_PPULSE    = 3'd1,
        S_PVERIFY   = 3'd2,
        S_PREPULSE  = 3'd3,
        S_PREVERIFY = 3'd4,
        S_EPULSE    = 3'd5,
        S_EVERIFY   = 3'd6,
        S_SUSP      = 3'd7
    } seq_state_e;
endpackage

// File: rtl/flash_seq_range.sv
module flash_seq_range #(
    parameter int ADDR_W     = 6,
    parameter int BSEL_W     = 3,
    parameter int NUM_BLOCKS = 5,
    parameter int BLK_SIZE   = 8
) (
    input  logic              whole_array,
    input  logic [BSEL_W-1:0] blk_sel,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi,
    output logic              valid
);
    localparam int DEPTH = NUM_BLOCKS * BLK_SIZE;

    always_comb begin
        if (whole_array) begin
            lo    = '0;
            hi    = ADDR_W'(DEPTH - 1);
            valid = 1'b1;
        end else begin
            lo    = ADDR_W'(int'(blk_sel) * BLK_SIZE);
            hi    = ADDR_W'(int'(blk_sel) * BLK_SIZE + BLK_SIZE - 1);
            valid = (int'(blk_sel) < NUM_BLOCKS);
        end
    end
endmodule

// File: rtl/flash_seq_match.sv
module flash_seq_match #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] target,
    output logic              hit
);
    assign hit = (rdata == target);
endmodule

// File: rtl/flash_algo_seq.sv
module flash_algo_seq
    import flash_seq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int NUM_BLOCKS  = 5,
    parameter int BLK_SIZE    = 8,
    parameter int PROG_PULSE  = 4,
    parameter int ERASE_PULSE = 8,
    parameter int PROG_RETRY  = 3,
    parameter int ERASE_RETRY = 4,
    localparam int DEPTH  = NUM_BLOCKS * BLK_SIZE,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int BSEL_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    input  logic [BSEL_W-1:0] blk_sel,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              arr_prog,
    output logic              arr_erase,
    output logic [ADDR_W-1:0] arr_lo,
    output logic [ADDR_W-1:0] arr_hi,
    output logic              busy,
    output logic              done,
    output logic              prog_fail,
    output logic              erase_fail,
    output logic              suspended
);
    localparam int MAX_PULSE = (PROG_PULSE > ERASE_PULSE) ? PROG_PULSE : ERASE_PULSE;
    localparam int MAX_TRY   = (PROG_RETRY > ERASE_RETRY) ? PROG_RETRY : ERASE_RETRY;
    localparam int CNT_W     = $clog2(MAX_PULSE + 1);
    localparam int TRY_W     = $clog2(MAX_TRY + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
        logic [TRY_W-1:0]  tries;
        logic              pend;
        logic              done;
        logic              pfail;
        logic              efail;
    } seq_reg_t;

    seq_reg_t r_q, r_d;

    logic [ADDR_W-1:0] rng_lo, rng_hi;
    logic              rng_valid;
    logic [DATA_W-1:0] verify_target;
    logic              verify_hit;

    flash_seq_range #(
        .ADDR_W(ADDR_W), .BSEL_W(BSEL_W),
        .NUM_BLOCKS(NUM_BLOCKS), .BLK_SIZE(BLK_SIZE)
    ) u_range (
        .whole_array(op == OP_CHIP),
        .blk_sel    (blk_sel),
        .lo         (rng_lo),
        .hi         (rng_hi),
        .valid      (rng_valid)
    );

    assign verify_target = (r_q.state == S_EVERIFY) ? '1 : r_q.data;

    flash_seq_match #(.DATA_W(DATA_W)) u_match (
        .rdata (arr_rdata),
        .target(verify_target),
        .hit   (verify_hit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (suspend_req && (r_q.state == S_EPULSE || r_q.state == S_EVERIFY))
            r_d.pend = 1'b1;
        case (r_q.state)
            S_IDLE: begin
                if (start && op != OP_NONE) begin
                    r_d.pfail = 1'b0;
                    r_d.efail = 1'b0;
                    r_d.pend  = 1'b0;
                    r_d.tries = TRY_W'(1);
                    r_d.cnt   = CNT_W'(PROG_PULSE - 1);
                    if (op == OP_PROG) begin
                        r_d.state = S_PPULSE;
                        r_d.addr  = start_addr;
                        r_d.data  = start_data;
                    end else if (rng_valid) begin
                        r_d.state = S_PREPULSE;
                        r_d.lo    = rng_lo;
                        r_d.hi    = rng_hi;
                        r_d.addr  = rng_lo;
                        r_d.data  = '0;
                    end else begin
                        r_d.efail = 1'b1;
                    end
                end
            end
            S_PPULSE, S_PREPULSE: begin
                if (r_q.cnt == '0)
                    r_d.state = (r_q.state == S_PPULSE) ? S_PVERIFY : S_PREVERIFY;
                else
                    r_d.cnt = r_q.cnt - CNT_W'(1);
            end
            S_PVERIFY: begin
                if (verify_hit) begin
                    r_d.done  = 1'b1;
                    r_d.state = S_IDLE;
                end else if (r_q.tries == TRY_W'(PROG_RETRY)) begin
                    r_d.pfail = 1'b1;
                    r_d.state = S_IDLE;
                end else begin
                    r_d.tries = r_q.tries + TRY_W'(1);
                    r_d.cnt   = CNT_W'(PROG_PULSE - 1);
                    r_d.state = S_PPULSE;
                end
            end
            S_PREVERIFY: begin
                if (verify_hit) begin
                    r_d.tries = TRY_W'(1);
                    if (r_q.addr == r_q.hi) begin
                        r_d.cnt   = CNT_W'(ERASE_PULSE - 1);
                        r_d.state = S_EPULSE;
                    end else begin
                        r_d.addr  = r_q.addr + ADDR_W'(1);
                        r_d.cnt   = CNT_W'(PROG_PULSE - 1);
                        r_d.state = S_PREPULSE;
                    end
                end else if (r_q.tries == TRY_W'(PROG_RETRY)) begin
                    r_d.efail = 1'b1;
                    r_d.state = S_IDLE;
                end else begin
                    r_d.tries = r_q.tries + TRY_W'(1);
                    r_d.cnt   = CNT_W'(PROG_PULSE - 1);
                    r_d.state = S_PREPULSE;
                end
            end
            S_EPULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.addr  = r_q.lo;
                    r_d.state = S_EVERIFY;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            S_EVERIFY: begin
                if (verify_hit) begin
                    if (r_q.addr == r_q.hi) begin
                        r_d.done  = 1'b1;
                        r_d.state = S_IDLE;
                    end else begin
                        r_d.addr = r_q.addr + ADDR_W'(1);
                    end
                end else if (r_q.tries == TRY_W'(ERASE_RETRY)) begin
                    r_d.efail = 1'b1;
                    r_d.state = S_IDLE;
                end else if (r_q.pend || suspend_req) begin
                    r_d.state = S_SUSP;
                end else begin
                    r_d.tries = r_q.tries + TRY_W'(1);
                    r_d.cnt   = CNT_W'(ERASE_PULSE - 1);
                    r_d.state = S_EPULSE;
                end
            end
            S_SUSP: begin
                if (resume_req) begin
                    r_d.pend  = 1'b0;
                    r_d.addr  = r_q.lo;
                    r_d.state = S_EVERIFY;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign arr_addr   = r_q.addr;
    assign arr_wdata  = r_q.data;
    assign arr_prog   = (r_q.state == S_PPULSE) || (r_q.state == S_PREPULSE);
    assign arr_erase  = (r_q.state == S_EPULSE);
    assign arr_lo     = r_q.lo;
    assign arr_hi     = r_q.hi;
    assign busy       = (r_q.state != S_IDLE);
    assign suspended  = (r_q.state == S_SUSP);
    assign done       = r_q.done;
    assign prog_fail  = r_q.pfail;
    assign erase_fail = r_q.efail;
endmodule

// File: rtl/flash_algo_seq_chk.sv
module flash_algo_seq_chk #(
    parameter int PROG_PULSE  = 4,
    parameter int ERASE_PULSE = 8
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic prog_fail,
    input logic erase_fail,
    input logic suspended,
    input logic arr_prog,
    input logic arr_erase
);
    logic [15:0] prun_q, erun_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prun_q <= '0;
            erun_q <= '0;
        end else begin
            prun_q <= arr_prog  ? prun_q + 16'd1 : 16'd0;
            erun_q <= arr_erase ? erun_q + 16'd1 : 16'd0;
        end
    end

    assert_idle_at_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (!busy && !arr_prog && !arr_erase));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_prog_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_prog && prun_q != 16'd0) |-> (prun_q == 16'(PROG_PULSE)));

    assert_fail_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_fail && erase_fail));

    assert_erase_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_erase && erun_q != 16'd0) |-> (erun_q == 16'(ERASE_PULSE)));

    assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_prog && arr_erase));

    assert_suspend_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> (busy && !arr_prog && !arr_erase));
endmodule

bind flash_algo_seq flash_algo_seq_chk #(
    .PROG_PULSE(PROG_PULSE), .ERASE_PULSE(ERASE_PULSE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .prog_fail(prog_fail), .erase_fail(erase_fail), .suspended(suspended),
    .arr_prog(arr_prog), .arr_erase(arr_erase)
);

// File: tb/sim_flash_algo_seq.sv
module sim_flash_algo_seq;
    import flash_seq_pkg::*;

    localparam int NB = 5, BS = 8, DEPTH = NB * BS;
    localparam int PP = 4, EP = 8, PR = 3, ER = 4;
    localparam int AW = 6, BW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [AW-1:0] start_addr = '0;
    logic [7:0]    start_data = '0;
    logic [BW-1:0] blk_sel = '0;
    logic          suspend_req = 1'b0, resume_req = 1'b0;
    logic [7:0]    arr_rdata;
    logic [AW-1:0] arr_addr, arr_lo, arr_hi;
    logic [7:0]    arr_wdata;
    logic          arr_prog, arr_erase, busy, done, prog_fail, erase_fail, suspended;

    logic [7:0] mem [DEPTH];
    logic [7:0] snap [DEPTH];
    int need [DEPTH];
    int pacc [DEPTH];
    int eneed, eacc, nprog, nerase, prun, erun, width_bad, prog_after_erase;
    int plog [64];
    logic prev_prog, prev_erase;
    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    assign arr_rdata = (int'(arr_addr) < DEPTH) ? mem[arr_addr] : 8'h00;

    flash_algo_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .start_addr(start_addr),
        .start_data(start_data), .blk_sel(blk_sel), .suspend_req(suspend_req),
        .resume_req(resume_req), .arr_rdata(arr_rdata), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_prog(arr_prog), .arr_erase(arr_erase),
        .arr_lo(arr_lo), .arr_hi(arr_hi), .busy(busy), .done(done),
        .prog_fail(prog_fail), .erase_fail(erase_fail), .suspended(suspended)
    );

    initial begin
        #1500000;
        $display("FAIL watchdog expired: act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // one cycle: wait for falling edge, then run the array model and monitors
    task automatic tick();
        @(negedge clk);
        if (arr_prog) begin
            pacc[arr_addr]++;
            if (pacc[arr_addr] >= need[arr_addr] * PP) mem[arr_addr] = mem[arr_addr] & arr_wdata;
            if (!prev_prog) begin
                if (nprog < 64) plog[nprog] = int'(arr_addr);
                nprog++;
                if (nerase != 0) prog_after_erase++;
            end
            prun++;
        end else if (prun != 0) begin
            if (prun != PP) width_bad++;
            prun = 0;
        end
        if (arr_erase) begin
            eacc++;
            if (eacc >= eneed * EP)
                for (int i = int'(arr_lo); i <= int'(arr_hi); i++) mem[i] = 8'hFF;
            if (!prev_erase) nerase++;
            erun++;
        end else if (erun != 0) begin
            if (erun != EP) width_bad++;
            erun = 0;
        end
        prev_prog  = arr_prog;
        prev_erase = arr_erase;
    endtask

    task automatic model_init(input int pattern);
        for (int i = 0; i < DEPTH; i++) begin
            case (pattern)
                0: mem[i] = 8'hFF;
                1: mem[i] = 8'((i * 29 + 7) ^ 8'h5A);
                default: mem[i] = 8'h0F;
            endcase
            need[i] = 1;
            pacc[i] = 0;
        end
        eneed = 1; eacc = 0; nprog = 0; nerase = 0;
        prun = 0; erun = 0; width_bad = 0; prog_after_erase = 0;
        prev_prog = 1'b0; prev_erase = 1'b0;
    endtask

    task automatic pulse_start(input logic [1:0] o, input int a, input int d, input int b);
        op = o; start_addr = AW'(a); start_data = 8'(d); blk_sel = BW'(b);
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    // result: 0 done, 1 prog_fail, 2 erase_fail, 3 timeout
    task automatic wait_end(input string req, output int res);
        res = 3;
        for (int c = 0; c < 5000; c++) begin
            if (done) begin res = 0; break; end
            if (prog_fail) begin res = 1; break; end
            if (erase_fail) begin res = 2; break; end
            tick();
        end
        if (res == 0) begin
            chk(!busy, {req, " busy low with done"}, busy, 0);
            tick();
            chk(!done, {req, " done one cycle"}, done, 0);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input int a, input int d, input int b,
                          input string req, output int res);
        pulse_start(o, a, d, b);
        chk(busy, {req, " busy after start"}, busy, 1);
        wait_end(req, res);
    endtask

    int res, bad;

    initial begin
        model_init(0);
        // R1: reset state
        tick();
        chk(!busy && !done && !suspended && !arr_prog && !arr_erase, "R1 outputs in reset",
            {busy, done, suspended, arr_prog, arr_erase}, 0);
        tick();
        rst_n = 1'b1;
        tick(); tick();
        chk(!busy && !prog_fail && !erase_fail, "R1 after reset",
            {busy, prog_fail, erase_fail}, 0);

        // R2: program every address with address-dependent data
        for (int a = 0; a < DEPTH; a++) begin
            model_init(0);
            run_op(OP_PROG, a, (a * 37 + 11) & 8'hFF, 0, "R2", res);
            chk(res == 0, "R2 program result", res, 0);
            chk(int'(mem[a]) == ((a * 37 + 11) & 8'hFF), "R2 programmed data", mem[a], (a * 37 + 11) & 8'hFF);
            chk(nprog == 1 && width_bad == 0, "R2 single pulse of right width", nprog * 100 + width_bad, 100);
        end

        // R3: retry counts up to the limit, then fail
        for (int k = 1; k <= PR + 1; k++) begin
            model_init(0);
            need[9] = k;
            run_op(OP_PROG, 9, 8'h3C, 0, "R3", res);
            chk(res == ((k <= PR) ? 0 : 1), "R3 result vs pulse need", res, (k <= PR) ? 0 : 1);
            chk(nprog == ((k <= PR) ? k : PR), "R3 pulse count", nprog, (k <= PR) ? k : PR);
        end
        chk(prog_fail, "R3 prog_fail held", prog_fail, 1);
        tick(); tick();
        chk(prog_fail, "R3 prog_fail sticky", prog_fail, 1);
        model_init(2);
        run_op(OP_PROG, 4, 8'hF0, 0, "R3", res);
        chk(res == 1 && nprog == PR, "R3 bit cannot rise", res * 100 + nprog, 100 + PR);

        // R4/R6: chip erase over patterned array
        model_init(1);
        run_op(OP_CHIP, 0, 0, 0, "R4", res);
        chk(res == 0, "R4 chip erase result", res, 0);
        chk(nprog == DEPTH && prog_after_erase == 0, "R4 pre-program count",
            nprog, DEPTH);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) if (plog[i] != i) bad++;
        chk(bad == 0, "R4 ascending pre-program order", bad, 0);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] != 8'hFF) bad++;
        chk(bad == 0 && nerase == 1 && width_bad == 0, "R6 erased array, one pulse",
            bad * 100 + nerase, 1);

        // R6/R7: erase pulse counts up to and past the limit
        for (int k = 1; k <= ER + 1; k++) begin
            model_init(1);
            eneed = k;
            run_op(OP_CHIP, 0, 0, 0, "R7", res);
            chk(res == ((k <= ER) ? 0 : 2), "R7 erase result", res, (k <= ER) ? 0 : 2);
            chk(nerase == ((k <= ER) ? k : ER), "R6 erase pulse count", nerase, (k <= ER) ? k : ER);
            chk(width_bad == 0, "R6 pulse widths", width_bad, 0);
        end

        // R5: each block
        for (int b = 0; b < NB; b++) begin
            model_init(1);
            for (int i = 0; i < DEPTH; i++) snap[i] = mem[i];
            run_op(OP_BLOCK, 0, 0, b, "R5", res);
            chk(res == 0, "R5 block erase result", res, 0);
            chk(nprog == BS && plog[0] == b * BS, "R5 pre-program range",
                nprog * 100 + plog[0], BS * 100 + b * BS);
            bad = 0;
            for (int i = 0; i < DEPTH; i++) begin
                if (i >= b * BS && i < (b + 1) * BS) begin
                    if (mem[i] != 8'hFF) bad++;
                end else if (mem[i] != snap[i]) bad++;
            end
            chk(bad == 0, "R5 block contents", bad, 0);
        end

        // R10: invalid block numbers
        for (int b = NB; b < 8; b++) begin
            model_init(0);
            pulse_start(OP_BLOCK, 0, 0, b);
            chk(erase_fail && !busy && nprog == 0, "R10 invalid block",
                {erase_fail, busy}, 2);
        end

        // R10: pre-program failure stops before erase
        model_init(0);
        need[10] = 255;
        run_op(OP_CHIP, 0, 0, 0, "R10", res);
        chk(res == 2 && nerase == 0 && nprog == 10 + PR, "R10 pre-program fail",
            res * 1000 + nerase * 100 + nprog, 2000 + 10 + PR);

        // R9: start while busy and op 00 ignored
        model_init(0);
        pulse_start(OP_BLOCK, 0, 0, 0);
        tick(); tick();
        pulse_start(OP_PROG, 39, 8'h00, 0);
        wait_end("R9", res);
        chk(res == 0 && mem[39] == 8'hFF && nprog == BS, "R9 start while busy ignored",
            int'(mem[39]), 255);
        model_init(0);
        pulse_start(OP_NONE, 3, 8'h00, 0);
        for (int c = 0; c < 5; c++) tick();
        chk(!busy && !done && nprog == 0, "R9 op 00 ignored", busy, 0);

        // R8: suspend between pulses, resume rescans
        model_init(1);
        eneed = 3;
        pulse_start(OP_CHIP, 0, 0, 0);
        for (int c = 0; c < 1000 && !arr_erase; c++) tick();
        suspend_req = 1'b1;
        tick();
        suspend_req = 1'b0;
        for (int c = 0; c < 200 && !suspended; c++) tick();
        chk(suspended && busy && nerase == 1, "R8 parked after first pulse",
            {suspended, busy} * 100 + nerase, 301);
        for (int c = 0; c < 20; c++) tick();
        chk(suspended && nerase == 1 && !arr_erase, "R8 no pulses while parked", nerase, 1);
        resume_req = 1'b1;
        tick();
        resume_req = 1'b0;
        wait_end("R8", res);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] != 8'hFF) bad++;
        chk(res == 0 && nerase == 3 && bad == 0, "R8 resumed erase completes",
            res * 100 + nerase, 3);
        model_init(0);
        need[2] = 2;
        pulse_start(OP_PROG, 2, 8'h81, 0);
        suspend_req = 1'b1;
        tick();
        suspend_req = 1'b0;
        bad = 0;
        for (int c = 0; c < 40 && !done; c++) begin
            if (suspended) bad++;
            tick();
        end
        chk(bad == 0 && done, "R8 suspend ignored outside erase", bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule